// File: doc/BRIEF.md
# I2S Transmit Serializer

This block turns a stream of 32-bit sample words into a standard I2S output and acts as master of both the bit clock and the word-select line. It divides the master clock to produce the bit clock, sequences left and right slots, and shifts each sample out MSB first. The slot width follows a resolution input, and only the low bits of each word are sent. With a master clock at 256 times the sample rate, a divide setting of 0 gives 32-bit stereo frames and a setting of 2 gives 16-bit stereo frames.

Samples arrive on a valid/ready stream, one word per channel slot, left first. The block raises `s_ready` for exactly one master-clock cycle at the start of each slot that takes data. A word moves only in a cycle where `s_valid` and `s_ready` are both high. `s_ready` depends only on internal state and `tx_en`, never on `s_valid`. A source that holds `s_valid` low is never waited for: that slot is sent as zeros and the block keeps running. Each time the transmitter starts, it sends one all-zero frame before taking any data. When `tx_en` drops, the block finishes the frame in progress and then parks all lines low.

Top module: `i2s_tx_serializer`

## Requirements
- R1: While running, `sck` holds each level for exactly `ratio`+2 master cycles, so its period is 2*(`ratio`+2) cycles. When idle, `sck` is low.
- R2: When the block starts (idle and `tx_en` high), the first frame is all zeros, no word is taken during it, and it begins with the left slot.
- R3: The slot width N is `res`; a `res` of 0 or above 32 means 32. A frame is 2N bit periods. `ws` is low for left and high for right, and it changes one bit period before the first bit of the slot it names.
- R4: Each slot sends bits N-1 down to 0 of its word, MSB first. `sd` changes only in the cycle where `sck` falls.
- R5: After the first frame, one word is taken per slot, left then right. `s_ready` is high for a single cycle: the cycle before the edge that drives the slot's first bit.
- R6: If `s_valid` is low when a slot starts, the slot is sent as zeros and no word is taken. A word offered later in that slot waits for the next slot start.
- R7: After `tx_en` goes low, the current frame completes. Then `sck`, `ws`, `sd` and `s_ready` stay low and no word is taken.
- R8: `ratio` and `res` are sampled at start and at each frame boundary. A change in the middle of a frame takes effect from the next frame.
- R9: During reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable |
| ratio | input | RATIO_W | Bit-clock divide setting |
| res | input | RES_W | Sample resolution in bits |
| s_valid | input | 1 | Sample word offered |
| s_ready | output | 1 | Block takes the offered word this cycle |
| s_data | input | WORD_W | Sample word, one channel |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select, low = left |
| sd | output | 1 | Serial data |

## Verification
Full 32-bit slots at the fastest divide use words with single high bits at each end and alternating patterns, which show whether bit order and left/right pairing are right. Narrow slots use words with set upper bits, which show that only the low field is sent, and a width of 1 tests the word-select lead at its limit. A source that is gated off, then released in the middle of a slot, separates "zeros and no take" from a late pop. Configuration changes in the middle of a frame, and a stop in the middle of a frame followed by a restart, test when the settings are sampled and that the zero frame comes back.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  // Per-cycle controls that the frame sequencer sends to the slot shifter
  typedef struct packed {
    logic load;     // a slot starts: replace the shift contents
    logic take_ok;  // this slot start may accept a word
    logic clear;    // leaving run state: flush the shifter
    logic shift;    // bit-clock falling edge: advance one bit
  } slot_ctl_t;

  // Slot width implied by the resolution field; out-of-range means full word
  function automatic int slot_len(int res_val, int word_w);
    return (res_val == 0 || res_val > word_w) ? word_w : res_val;
  endfunction

endpackage

// File: rtl/i2s_tx_bclk_div.sv
module i2s_tx_bclk_div #(
  parameter int HALF_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half_len,
  output logic              sck,
  output logic              fall_tick
);

  localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

  logic [HALF_W-1:0] cnt_q;
  logic              sck_q;
  logic              at_end;

  assign at_end    = (cnt_q == half_len - ONE);
  assign fall_tick = run && sck_q && at_end;
  assign sck       = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (at_end) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

endmodule

// File: rtl/i2s_tx_frame_seq.sv
module i2s_tx_frame_seq
  import i2s_tx_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int RATIO_W = 8,
  parameter int RES_W   = 6,
  parameter int CNT_W   = 7,
  parameter int HALF_W  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [RES_W-1:0]   res,
  input  logic               fall_tick,
  output logic               run,
  output logic [HALF_W-1:0]  half_len,
  output logic               ws,
  output slot_ctl_t          ctl,
  output logic [CNT_W-1:0]   load_len
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic               run_q, zero_q, ws_q;
  logic [CNT_W-1:0]   pos_q, len_q;
  logic [RATIO_W-1:0] ratio_q;

  logic [CNT_W-1:0]   res_len, len_use, pos_nx;
  logic               last, start, stop, wrap, mid, restart, ws_nx;

  assign res_len = CNT_W'(slot_len(int'(res), WORD_W));
  assign last    = (pos_q == ((len_q << 1) - ONE));
  assign start   = !run_q && tx_en;
  assign stop    = fall_tick && last && !tx_en;
  assign wrap    = fall_tick && last && tx_en;
  assign mid     = fall_tick && !last && ((pos_q + ONE) == len_q);
  assign restart = start || wrap;

  assign len_use = restart ? res_len : len_q;
  assign pos_nx  = restart ? '0 : pos_q + ONE;
  // word select announces the channel of the following bit position
  assign ws_nx   = (pos_nx >= len_use - ONE) && (pos_nx != ((len_use << 1) - ONE));

  assign ctl.load    = restart || mid;
  assign ctl.take_ok = wrap || (mid && !zero_q);
  assign ctl.clear   = stop;
  assign ctl.shift   = fall_tick;

  assign run      = run_q;
  assign ws       = ws_q;
  assign load_len = len_use;
  assign half_len = HALF_W'(ratio_q) + HALF_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      zero_q  <= 1'b0;
      ws_q    <= 1'b0;
      pos_q   <= '0;
      len_q   <= CNT_W'(WORD_W);
      ratio_q <= '0;
    end else if (start) begin
      run_q   <= 1'b1;
      zero_q  <= 1'b1;
      ws_q    <= ws_nx;
      pos_q   <= '0;
      len_q   <= res_len;
      ratio_q <= ratio;
    end else if (stop) begin
      run_q   <= 1'b0;
      zero_q  <= 1'b0;
      ws_q    <= 1'b0;
      pos_q   <= '0;
    end else if (fall_tick) begin
      pos_q <= pos_nx;
      ws_q  <= ws_nx;
      if (wrap) begin
        len_q   <= res_len;
        ratio_q <= ratio;
        zero_q  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/i2s_tx_slot_shift.sv
module i2s_tx_slot_shift #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              take,
  input  logic              clear,
  input  logic              shift,
  input  logic [WORD_W-1:0] data,
  input  logic [CNT_W-1:0]  load_len,
  output logic              sd
);

  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  align;

  // move the low load_len bits up so the field's MSB sits at the top
  assign align = CNT_W'(WORD_W) - load_len;
  assign sd    = shreg_q[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
    end else if (clear) begin
      shreg_q <= '0;
    end else if (load) begin
      shreg_q <= take ? (data << align) : '0;
    end else if (shift) begin
      shreg_q <= shreg_q << 1;
    end
  end

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
  import i2s_tx_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int RATIO_W = 8,
  parameter int RES_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [RES_W-1:0]   res,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [WORD_W-1:0]  s_data,
  output logic               sck,
  output logic               ws,
  output logic               sd
);

  localparam int CNT_W  = $clog2(2 * WORD_W + 1);
  localparam int HALF_W = RATIO_W + 1;

  logic              run;
  logic              fall_tick;
  logic [HALF_W-1:0] half_len;
  logic [CNT_W-1:0]  load_len;
  slot_ctl_t         ctl;
  logic              take;

  assign s_ready = ctl.take_ok;
  assign take    = s_ready && s_valid;

  i2s_tx_bclk_div #(
    .HALF_W (HALF_W)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .half_len  (half_len),
    .sck       (sck),
    .fall_tick (fall_tick)
  );

  i2s_tx_frame_seq #(
    .WORD_W  (WORD_W),
    .RATIO_W (RATIO_W),
    .RES_W   (RES_W),
    .CNT_W   (CNT_W),
    .HALF_W  (HALF_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .ratio     (ratio),
    .res       (res),
    .fall_tick (fall_tick),
    .run       (run),
    .half_len  (half_len),
    .ws        (ws),
    .ctl       (ctl),
    .load_len  (load_len)
  );

  i2s_tx_slot_shift #(
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctl.load),
    .take     (take),
    .clear    (ctl.clear),
    .shift    (ctl.shift),
    .data     (s_data),
    .load_len (load_len),
    .sd       (sd)
  );

endmodule

// File: rtl/i2s_tx_serializer_chk.sv
module i2s_tx_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic ws,
  input logic sd,
  input logic s_ready
);

  // R1
  sck_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |=> $stable(sck));

  // R1
  sck_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |=> $stable(sck));

  // R4
  sd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd) |-> $fell(sck));

  // R3
  ws_drop_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ws) |-> $fell(sck));

  // R5
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);

  // R5
  ready_then_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> $fell(sck));

endmodule

bind i2s_tx_serializer i2s_tx_serializer_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sck     (sck),
  .ws      (ws),
  .sd      (sd),
  .s_ready (s_ready)
);

// File: tb/i2s_tx_serializer_bench.sv
module i2s_tx_serializer_bench;

  localparam int WORD_W = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0;
  logic [7:0]  ratio = 8'd0;
  logic [5:0]  res = 6'd32;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_data = 32'h0;
  logic        sck, ws, sd;

  always #5 clk = ~clk;

  i2s_tx_serializer u_i2s_tx_serializer (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ratio(ratio), .res(res),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .sck(sck), .ws(ws), .sd(sd)
  );

  int    tests = 0, fails = 0;
  bit    done = 0;
  string phase = "reset";

  logic [31:0] src_q[$];
  bit    allow = 1;
  bit    hs = 0;
  int    pops = 0, zero_pops = 0, zf_ones = 0, sd_ones = 0;

  // behavioural reference: bit position within a frame, slot word held whole
  bit          m_run = 0, m_sck = 0, m_zero = 0;
  int          m_cnt = 0, m_half = 2, m_pos = 0, m_n = 1;
  logic [31:0] m_word = 0;

  function automatic int clamp_len(int r);
    return (r == 0 || r > WORD_W) ? WORD_W : r;
  endfunction

  function automatic bit m_ws();
    if (!m_run) return 0;
    return ((m_pos + 1) % (2 * m_n)) >= m_n;
  endfunction

  function automatic bit m_sd();
    if (!m_run) return 0;
    return m_word[m_n - 1 - (m_pos % m_n)];
  endfunction

  function automatic bit m_ready();
    if (!(m_run && m_sck && m_cnt == m_half - 1)) return 0;
    if (m_pos == 2 * m_n - 1) return tx_en;
    return (m_pos + 1 == m_n) && !m_zero;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_sck = 0; m_cnt = 0; m_pos = 0; m_n = 1; m_half = 2;
      m_zero = 0; m_word = 0;
    end else if (!m_run) begin
      if (tx_en) begin
        m_run = 1; m_cnt = 0; m_sck = 0; m_pos = 0; m_n = clamp_len(int'(res));
        m_half = int'(ratio) + 2; m_zero = 1; m_word = 0;
      end
    end else if (m_cnt != m_half - 1) begin
      m_cnt++;
    end else begin
      m_cnt = 0;
      if (!m_sck) begin
        m_sck = 1;
      end else begin
        m_sck = 0;
        if (m_pos == 2 * m_n - 1) begin
          if (!tx_en) begin
            m_run = 0; m_pos = 0; m_word = 0; m_zero = 0;
          end else begin
            m_pos = 0; m_n = clamp_len(int'(res)); m_half = int'(ratio) + 2;
            m_zero = 0; m_word = s_valid ? s_data : 32'h0;
          end
        end else begin
          m_pos++;
          if (m_pos == m_n) m_word = (!m_zero && s_valid) ? s_data : 32'h0;
        end
      end
    end
  end

  // source, per-cycle comparison, handshake bookkeeping
  always begin
    bit bad;
    @(negedge clk);
    if (hs) begin
      void'(src_q.pop_front());
      pops++;
    end
    s_valid = allow && (src_q.size() > 0);
    s_data  = (src_q.size() > 0) ? src_q[0] : 32'h0;
    #2;
    if (rst_n && !done) begin
      tests++;
      bad = 0;
      if (sck !== m_sck) begin
        $display("FAIL R1 [%s] sck got %0b exp %0b at %0t", phase, sck, m_sck, $time); bad = 1;
      end
      if (ws !== m_ws()) begin
        $display("FAIL R3 [%s] ws got %0b exp %0b at %0t", phase, ws, m_ws(), $time); bad = 1;
      end
      if (sd !== m_sd()) begin
        $display("FAIL R4 [%s] sd got %0b exp %0b at %0t", phase, sd, m_sd(), $time); bad = 1;
      end
      if (s_ready !== m_ready()) begin
        $display("FAIL R5 [%s] s_ready got %0b exp %0b at %0t", phase, s_ready, m_ready(), $time); bad = 1;
      end
      if (bad) fails++;
    end
    hs = s_valid && s_ready;
    if (hs && m_run && m_zero && m_pos != 2 * m_n - 1) zero_pops++;
    if (m_run && m_zero && sd) zf_ones++;
    if (sd) sd_ones++;
  end

  task automatic dcheck(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d exp %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_and_idle();
    int guard = 0;
    int p0;
    tx_en = 1'b0;
    while (m_run && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    p0 = pops;
    cycles(20);
    #3;
    dcheck(!sck && !ws && !sd && !s_ready, "R7", "lines idle after stop",
           int'({sck, ws, sd, s_ready}), 0);
    dcheck(pops == p0, "R7", "no take while idle", pops, p0);
  endtask

  initial begin
    cycles(3);
    #3;
    // R9: reset state
    dcheck(!sck && !ws && !sd && !s_ready, "R9", "outputs during reset",
           int'({sck, ws, sd, s_ready}), 0);
    rst_n = 1'b1;
    cycles(4);

    // R2 R4 R5: full 32-bit slots, fastest divide
    phase = "R4 32-bit slots";
    res = 6'd32; ratio = 8'd0;
    src_q.push_back(32'h8000_0001); src_q.push_back(32'hA5A5_5A5A);
    src_q.push_back(32'hFFFF_0000); src_q.push_back(32'h0000_FFFF);
    src_q.push_back(32'h1234_5678); src_q.push_back(32'hC0DE_F00D);
    tx_en = 1'b1;
    cycles(256 * 4 + 40);
    dcheck(src_q.size() == 0, "R5", "all words taken in three frames", src_q.size(), 0);
    dcheck(zero_pops == 0, "R2", "takes during start frame", zero_pops, 0);
    dcheck(zf_ones == 0, "R2", "ones sent in start frame", zf_ones, 0);
    stop_and_idle();

    // R3: 16-bit slots, upper bits of words must not appear
    phase = "R3 16-bit slots";
    res = 6'd16; ratio = 8'd2;
    src_q.push_back(32'hDEAD_1234); src_q.push_back(32'hFFFF_8001);
    src_q.push_back(32'h7777_00FF); src_q.push_back(32'h0F0F_F0F0);
    tx_en = 1'b1;
    cycles(256 * 3 + 40);
    dcheck(src_q.size() == 0, "R3", "words taken at 16-bit framing", src_q.size(), 0);
    stop_and_idle();

    // R6: empty source sends zeros and takes nothing
    phase = "R6 empty source";
    res = 6'd8; ratio = 8'd1;
    allow = 0;
    src_q.push_back(32'h0000_00C3); src_q.push_back(32'h0000_0081);
    sd_ones = 0;
    begin
      int p0;
      p0 = pops;
      tx_en = 1'b1;
      cycles(96 * 3);
      dcheck(pops == p0, "R6", "takes while source empty", pops - p0, 0);
      dcheck(sd_ones == 0, "R6", "ones sent while source empty", sd_ones, 0);
    end
    cycles(7);
    allow = 1;
    phase = "R6 late offer";
    cycles(96 * 2);
    dcheck(src_q.size() == 0, "R6", "late words taken at slot starts", src_q.size(), 0);
    stop_and_idle();

    // R8: settings changed mid-frame, including out-of-range and width 1
    phase = "R8 mid-frame change";
    res = 6'd0; ratio = 8'd1;
    for (int i = 0; i < 10; i++) src_q.push_back(32'h9000_0003 ^ (32'h1357_9BDF * i));
    tx_en = 1'b1;
    cycles(150);
    res = 6'd5; ratio = 8'd3;
    cycles(700);
    res = 6'd1; ratio = 8'd0;
    cycles(300);
    res = 6'd45;
    cycles(100);
    phase = "R7 stop mid-frame";
    stop_and_idle();

    // R2: restart brings back the zero frame
    phase = "R2 restart";
    zero_pops = 0; zf_ones = 0;
    res = 6'd4; ratio = 8'd0;
    for (int i = 0; i < 6; i++) src_q.push_back(32'hFFFF_FFF0 | i);
    tx_en = 1'b1;
    cycles(32 * 5);
    dcheck(zero_pops == 0, "R2", "takes during restart frame", zero_pops, 0);
    dcheck(zf_ones == 0, "R2", "ones sent in restart frame", zf_ones, 0);
    stop_and_idle();

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: run did not end, got hang exp finish");
    finish_run();
  end

endmodule